// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns an active-low, asynchronous interrupt pin into a maskable interrupt request for a processor. The pin is brought into the clock domain through a synchronizer chain. A falling edge, or a held low level when that sensitivity is selected, sets a pending latch. The latch stays set until the processor fetches the interrupt vector, software writes a one to the acknowledge bit, or reset is applied.

Software reaches the block through one five-bit control/status word. It has a write strobe and write data, and it reads back continuously. The word holds the enable, sensitivity, mask, acknowledge and pending bits. The request output is driven high only while the latch is set, the function is enabled and the mask is clear.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the pending flag, enable, sensitivity and mask bits all read 0, the acknowledge bit reads 0, and `irq_req` is 0.
- R2: With enable set, a falling edge on `pin_n` sets the pending flag (bit 4). It becomes visible after the SYNC_STAGES+1'th rising clock edge that follows the pin change, which is the third edge with the default of 2.
- R3: While the enable bit (bit 0) is 0, no pin activity sets the pending flag and `irq_req` stays 0.
- R4: With the sensitivity bit (bit 1) at 0, the pin responds to edges only. A pin held low after an acknowledge does not set the flag again.
- R5: With the sensitivity bit at 1, a low synchronized pin sets the flag on every cycle. An acknowledge therefore leaves the flag set until the pin returns high.
- R6: A one-cycle pulse on `vec_ack` clears the pending flag on the next edge when no new set condition is present.
- R7: A write with bit 3 set clears the pending flag. A write with bit 3 at 0 leaves the flag unchanged, and bit 3 always reads 0.
- R8: When a set condition and a clear arrive in the same cycle, the set wins and the flag stays 1.
- R9: `irq_req` is 1 exactly when the pending flag, the enable bit and a clear mask bit (bit 2) coincide. The pending flag reads back regardless of the mask.
- R10: `ctl_rdata` returns {pending, 0, mask, sensitivity, enable} in bits 4 down to 0. A write loads bits 0 to 2 from `ctl_wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write data |
| ctl_rdata | output | 5 | Control/status read data |
| vec_ack | input | 1 | Vector-fetch acknowledge strobe from the processor |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. With that setting the edge-to-pending latency is a short, fixed three cycles. Directed steps can therefore place a vector fetch in exactly the cycle in which the detected edge is live, which exercises the set-over-clear priority. The random phase toggles the pin, the mode and the strobes at rates that make edges, held lows and coincident acknowledges frequent within a few thousand cycles.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  input  logic       ctl_we,
  input  logic [4:0] ctl_wdata,
  output logic [4:0] ctl_rdata,
  input  logic       vec_ack,
  output logic       irq_req
);
  localparam int EN_B   = 0;
  localparam int MODE_B = 1;
  localparam int MASK_B = 2;
  localparam int ACK_B  = 3;

  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, en_q, mode_q, mask_q, pend_q;
  logic pin_lo, fall, set_ev, clr_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_lo = ~sync_q[SYNC_STAGES-1];
  assign fall   = prev_q & pin_lo;
  assign set_ev = en_q & (fall | (mode_q & pin_lo));
  assign clr_ev = vec_ack | (ctl_we & ctl_wdata[ACK_B]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      mask_q <= 1'b0;
    end else if (ctl_we) begin
      en_q   <= ctl_wdata[EN_B];
      mode_q <= ctl_wdata[MODE_B];
      mask_q <= ctl_wdata[MASK_B];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (set_ev) pend_q <= 1'b1;
    else if (clr_ev) pend_q <= 1'b0;
  end

  assign ctl_rdata = {pend_q, 1'b0, mask_q, mode_q, en_q};
  assign irq_req   = pend_q & en_q & ~mask_q;
endmodule

module ext_irq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic mode,
  input logic mask,
  input logic pend,
  input logic fall,
  input logic pin_lo,
  input logic we,
  input logic wack,
  input logic vec_ack,
  input logic irq
);
  // R2
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && fall |=> pend);
  // R5
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && mode && pin_lo |=> pend);
  // R6
  vec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack && !(en && (fall || (mode && pin_lo))) |=> !pend);
  // R7
  wzero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we && !wack && !vec_ack && pend |=> pend);
  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !pend |=> !pend);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend && en && !mask);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .mask(mask_q),
  .pend(pend_q), .fall(fall), .pin_lo(pin_lo), .we(ctl_we),
  .wack(ctl_wdata[3]), .vec_ack(vec_ack), .irq(irq_req)
);

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  localparam int NS = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1;
  logic ctl_we = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic vec_ack = 1'b0;
  logic [4:0] ctl_rdata;
  logic irq_req;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl #(.SYNC_STAGES(NS)) uut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .vec_ack(vec_ack),
    .irq_req(irq_req)
  );

  logic [NS-1:0] m_sync;
  logic m_prev, m_en, m_mode, m_mask, m_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_sync <= '1; m_prev <= 1'b1;
      m_en <= 0; m_mode <= 0; m_mask <= 0; m_pend <= 0;
    end else begin
      m_sync <= {m_sync[NS-2:0], pin_n};
      m_prev <= m_sync[NS-1];
      if (ctl_we) begin
        m_en <= ctl_wdata[0]; m_mode <= ctl_wdata[1]; m_mask <= ctl_wdata[2];
      end
      if (m_en && ((m_prev && !m_sync[NS-1]) || (m_mode && !m_sync[NS-1])))
        m_pend <= 1'b1;
      else if (vec_ack || (ctl_we && ctl_wdata[3]))
        m_pend <= 1'b0;
    end
  end

  function automatic logic [4:0] exp_rdata();
    return {m_pend, 1'b0, m_mask, m_mode, m_en};
  endfunction

  function automatic logic exp_irq();
    return m_pend & m_en & ~m_mask;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("R10 model rdata", ctl_rdata, exp_rdata());
    chk("R9 model irq", irq_req, exp_irq());
  endtask

  task automatic wr(logic [4:0] d);
    ctl_we = 1; ctl_wdata = d;
    tick();
    ctl_we = 0; ctl_wdata = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    void'($urandom(32'd7411));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    tick();
    // R1
    chk("R1 reset rdata", ctl_rdata, 5'b00000);
    chk("R1 reset irq", irq_req, 1'b0);
    // R3
    pin_n = 0; ticks(5);
    chk("R3 disabled pend", ctl_rdata[4], 1'b0);
    chk("R3 disabled irq", irq_req, 1'b0);
    pin_n = 1; ticks(3);
    wr(5'b00001);
    chk("R10 readback", ctl_rdata, 5'b00001);
    // R2
    pin_n = 0; ticks(2);
    chk("R2 not yet", ctl_rdata[4], 1'b0);
    tick();
    chk("R2 pend set", ctl_rdata[4], 1'b1);
    chk("R2 irq", irq_req, 1'b1);
    // R4 and R7: write-one ack while pin still low in edge mode
    wr(5'b01001); ticks(4);
    chk("R4 edge only no reset", ctl_rdata[4], 1'b0);
    chk("R7 ack clears", irq_req, 1'b0);
    pin_n = 1; ticks(3); pin_n = 0; ticks(3);
    chk("R2 second edge", ctl_rdata[4], 1'b1);
    wr(5'b00001);
    chk("R7 write zero keeps", ctl_rdata[4], 1'b1);
    chk("R7 ack reads zero", ctl_rdata[3], 1'b0);
    // R6
    vec_ack = 1; tick(); vec_ack = 0;
    chk("R6 vector clears", ctl_rdata[4], 1'b0);
    // R5
    wr(5'b00011); ticks(2);
    chk("R5 level sets", ctl_rdata[4], 1'b1);
    vec_ack = 1; tick(); vec_ack = 0;
    chk("R5 ack held", ctl_rdata[4], 1'b1);
    pin_n = 1; ticks(3);
    vec_ack = 1; tick(); vec_ack = 0;
    chk("R5 released", ctl_rdata[4], 1'b0);
    // R9
    wr(5'b00101);
    pin_n = 0; ticks(3);
    chk("R9 masked pend visible", ctl_rdata[4], 1'b1);
    chk("R9 masked irq", irq_req, 1'b0);
    chk("R10 full readback", ctl_rdata, 5'b10101);
    // R8
    pin_n = 1; wr(5'b01001); ticks(3);
    chk("R8 precondition", ctl_rdata[4], 1'b0);
    pin_n = 0; ticks(2);
    vec_ack = 1; tick(); vec_ack = 0;
    chk("R8 set beats clear", ctl_rdata[4], 1'b1);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 5) == 0) pin_n = ~pin_n;
      vec_ack = ($urandom_range(0, 9) == 0);
      ctl_we = ($urandom_range(0, 11) == 0);
      ctl_wdata = 5'($urandom);
      if ($urandom_range(0, 9) != 0) ctl_wdata[0] = 1'b1;
      tick();
    end
    ctl_we = 0; vec_ack = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule